// File: doc/BRIEF.md
# CAN Gateway Transmit Scheduler

This block sits in front of a single CAN transmit port and shares it among several client applications. Every client owns a private frame FIFO inside the block. A client stores a frame token in a free slot of its FIFO and only afterwards publishes a new value of its write counter. The scheduler keeps one read counter per client and treats a FIFO as holding data when the two counters differ.

Arbitration is a time-sliced rotation that steps once per CAN bit period. On each bit-period strobe, and only while the bus is idle, exactly one client is polled. Clients are visited in a fixed sequence given by a static configuration table, which lists them by ascending CAN identifier rather than by port number. If the polled FIFO holds a frame, the frame is handed to the transmit port with a one-cycle start pulse. Polling is then frozen until the transmitter has shown the bus busy and idle again. The pointer has already moved to the next client in the sequence. A client that just missed its slot therefore waits for every other client's slot before it is served.

Top module: `can_gw_tx_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, `tx_start` is 0, `tx_frame` and `tx_client` are 0, every read counter on `rd_cnt` is 0, and the rotation sits at the first entry of the order table.
- R2: A token written into a FIFO slot is not sent while that client's published write counter still equals its read counter; it becomes eligible only once the counter has been updated.
- R3: A poll takes place only on a clock edge where `bit_tick` and `bus_idle` are both 1. When `bus_idle` is 0, no frame starts no matter how many strobes arrive.
- R4: When the polled client's write counter differs from its read counter, the block acts on the clock edge after the polling edge. `tx_start` is 1 for that one cycle. `tx_frame` carries the token stored at the slot addressed by the read counter, and `tx_client` carries the client index. That client's `rd_cnt` increases by one, and `tx_frame` and `tx_client` then hold their values until the next start.
- R5: Each poll visits exactly one client. Successive polls follow the order table cyclically, wrapping from the last entry to the first. With the default table (3, 0, 5, 1, 4, 2), the first poll after reset visits client 3. A poll of an empty client uses up its slot.
- R6: After a start the pointer has already advanced to the next table entry. No further poll happens until `bus_idle` has been seen at 0 and then at 1 again, even if `bus_idle` stays 1 throughout.
- R7: Counters are PTR_W+1 bits wide and wrap. The FIFO slot is the low PTR_W bits of the counter. Frames of one client leave in the order they were published, including across the counter wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe at the start of each CAN bit period |
| bus_idle | input | 1 | 1 while the CAN transmit side is idle |
| tok_we | input | NUM_CLI | Per-client token write enable |
| tok_slot | input | NUM_CLI x PTR_W | Per-client FIFO slot being written |
| tok_data | input | NUM_CLI x FRM_W | Per-client frame token (identifier, length, payload) |
| wr_cnt | input | NUM_CLI x (PTR_W+1) | Per-client published write counter |
| rd_cnt | output | NUM_CLI x (PTR_W+1) | Per-client read counter, returned to the clients |
| tx_start | output | 1 | One-cycle pulse: a frame is handed to the transmitter |
| tx_client | output | IDX_W | Client whose frame was started |
| tx_frame | output | FRM_W | Frame token being transmitted |

## Verification
The properties rely on four conditions holding. A client never has more frames outstanding than the FIFO depth. A token is in storage at least one edge before its counter update. The order table is a permutation of the client indices. The bit strobe lasts a single cycle. The stimulus writes each token one edge ahead of publishing its counter and checks `rd_cnt` before loading more than three frames into one FIFO. It drives `bit_tick` as an isolated one-cycle pulse every four cycles. A small transmitter model lowers `bus_idle` for a few cycles after each start, or pins it high or low when a case calls for that.

// File: rtl/can_gw_pkg.sv
package can_gw_pkg;

    // Frame token carried through each client FIFO
    typedef struct packed {
        logic [10:0] ident;
        logic [3:0]  len;
        logic [63:0] payload;
    } can_frm_t;

    localparam int FRM_W = $bits(can_frm_t);

    // Scheduler poll state
    typedef enum logic {
        SCH_READY = 1'b0,   // polling allowed on idle strobes
        SCH_HOLD  = 1'b1    // frame launched, waiting for bus activity
    } sch_state_t;

    // Cyclic successor of a table position
    function automatic int unsigned next_pos(input int unsigned p, input int unsigned n);
        return (p + 1 >= n) ? 0 : p + 1;
    endfunction

endpackage

// File: rtl/can_gw_tok_store.sv
module can_gw_tok_store
    import can_gw_pkg::*;
#(
    parameter int NUM_CLI = 6,
    parameter int PTR_W   = 2,
    parameter int IDX_W   = 3
) (
    input  logic                              clk,
    input  logic [NUM_CLI-1:0]                wr_en,
    input  logic [NUM_CLI-1:0][PTR_W-1:0]     wr_slot,
    input  logic [NUM_CLI-1:0][FRM_W-1:0]     wr_data,
    input  logic [IDX_W-1:0]                  rd_cli,
    input  logic [PTR_W-1:0]                  rd_slot,
    output logic [FRM_W-1:0]                  rd_data
);
    localparam int DEPTH = 1 << PTR_W;

    logic [FRM_W-1:0] bank_out [NUM_CLI];

    for (genvar c = 0; c < NUM_CLI; c++) begin : g_bank
        logic [FRM_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en[c]) begin
                bank[wr_slot[c]] <= wr_data[c];
            end
        end

        assign bank_out[c] = bank[rd_slot];
    end

    assign rd_data = bank_out[rd_cli];

endmodule

// File: rtl/can_gw_rot_seq.sv
module can_gw_rot_seq
    import can_gw_pkg::*;
#(
    parameter int          NUM_CLI = 6,
    parameter int          IDX_W   = 3,
    parameter int unsigned ORDER [NUM_CLI] = '{3, 0, 5, 1, 4, 2}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [IDX_W-1:0] cur_cli
);
    localparam int POS_W = (NUM_CLI > 1) ? $clog2(NUM_CLI) : 1;

    logic [POS_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (step) begin
            pos <= POS_W'(next_pos(int'(pos), NUM_CLI));
        end
    end

    assign cur_cli = IDX_W'(ORDER[pos]);

    if (NUM_CLI > 1) begin : g_chk
        AST_STEP_NEW_CLIENT: assert property (@(posedge clk) disable iff (rst)
            step |=> cur_cli != $past(cur_cli))
            else $error("rotation step did not change client"); // R5
    end

endmodule

// File: rtl/can_gw_tx_sched.sv
module can_gw_tx_sched
    import can_gw_pkg::*;
#(
    parameter int          NUM_CLI = 6,
    parameter int          PTR_W   = 2,
    parameter int unsigned ORDER [NUM_CLI] = '{3, 0, 5, 1, 4, 2}
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   bit_tick,
    input  logic                                   bus_idle,
    input  logic [NUM_CLI-1:0]                     tok_we,
    input  logic [NUM_CLI-1:0][PTR_W-1:0]          tok_slot,
    input  logic [NUM_CLI-1:0][FRM_W-1:0]          tok_data,
    input  logic [NUM_CLI-1:0][PTR_W:0]            wr_cnt,
    output logic [NUM_CLI-1:0][PTR_W:0]            rd_cnt,
    output logic                                   tx_start,
    output logic [((NUM_CLI > 1) ? $clog2(NUM_CLI) : 1)-1:0] tx_client,
    output logic [FRM_W-1:0]                       tx_frame
);
    localparam int IDX_W = (NUM_CLI > 1) ? $clog2(NUM_CLI) : 1;
    localparam int CNT_W = PTR_W + 1;

    sch_state_t       state;
    logic [IDX_W-1:0] cur_cli;
    logic [FRM_W-1:0] head_frm;
    logic [CNT_W-1:0] cur_rd;
    logic             has_frame;
    logic             poll;
    logic             launch;

    can_gw_rot_seq #(
        .NUM_CLI (NUM_CLI),
        .IDX_W   (IDX_W),
        .ORDER   (ORDER)
    ) u_rot (
        .clk     (clk),
        .rst     (rst),
        .step    (poll),
        .cur_cli (cur_cli)
    );

    can_gw_tok_store #(
        .NUM_CLI (NUM_CLI),
        .PTR_W   (PTR_W),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (tok_we),
        .wr_slot (tok_slot),
        .wr_data (tok_data),
        .rd_cli  (cur_cli),
        .rd_slot (cur_rd[PTR_W-1:0]),
        .rd_data (head_frm)
    );

    assign cur_rd    = rd_cnt[cur_cli];
    assign has_frame = (wr_cnt[cur_cli] != cur_rd);
    assign poll      = bit_tick && bus_idle && (state == SCH_READY);
    assign launch    = poll && has_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SCH_READY;
            rd_cnt    <= '0;
            tx_start  <= 1'b0;
            tx_client <= '0;
            tx_frame  <= '0;
        end else begin
            tx_start <= launch;
            if (launch) begin
                tx_frame         <= head_frm;
                tx_client        <= cur_cli;
                rd_cnt[cur_cli]  <= cur_rd + 1'b1;
            end
            case (state)
                SCH_READY: if (launch)    state <= SCH_HOLD;
                SCH_HOLD:  if (!bus_idle) state <= SCH_READY;
                default:                  state <= SCH_READY;
            endcase
        end
    end

    AST_START_ON_IDLE_TICK: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> $past(bit_tick) && $past(bus_idle))
        else $error("start without idle strobe"); // R3

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !tx_start |-> $stable(tx_frame) && $stable(tx_client))
        else $error("output changed without start"); // R4

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start)
        else $error("start pulse longer than one cycle"); // R6

    for (genvar c = 0; c < NUM_CLI; c++) begin : g_cnt_chk
        AST_RD_ADV_ON_START: assert property (@(posedge clk) disable iff (rst)
            rd_cnt[c] != $past(rd_cnt[c]) |-> tx_start && (tx_client == IDX_W'(c)))
            else $error("read counter moved without start"); // R4

        AST_RD_NEEDS_PUBLISH: assert property (@(posedge clk) disable iff (rst)
            rd_cnt[c] != $past(rd_cnt[c]) |-> $past(wr_cnt[c] != rd_cnt[c]))
            else $error("read past published counter"); // R2
    end

endmodule

// File: tb/sim_can_gw_tx_sched.sv
module sim_can_gw_tx_sched;
    import can_gw_pkg::*;

    localparam int NC   = 6;
    localparam int PW   = 2;
    localparam int IW   = 3;
    localparam int CW   = PW + 1;
    localparam int unsigned ORD [NC] = '{3, 0, 5, 1, 4, 2};

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       bit_tick = 1'b0;
    logic                       bus_idle = 1'b1;
    logic [NC-1:0]              tok_we = '0;
    logic [NC-1:0][PW-1:0]      tok_slot = '0;
    logic [NC-1:0][FRM_W-1:0]   tok_data = '0;
    logic [NC-1:0][CW-1:0]      wr_cnt = '0;
    logic [NC-1:0][CW-1:0]      rd_cnt;
    logic                       tx_start;
    logic [IW-1:0]              tx_client;
    logic [FRM_W-1:0]           tx_frame;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    can_gw_tx_sched #(.NUM_CLI(NC), .PTR_W(PW), .ORDER(ORD)) u0 (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .bus_idle(bus_idle),
        .tok_we(tok_we), .tok_slot(tok_slot), .tok_data(tok_data),
        .wr_cnt(wr_cnt), .rd_cnt(rd_cnt), .tx_start(tx_start),
        .tx_client(tx_client), .tx_frame(tx_frame)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [FRM_W-1:0] mk_frame(input int c, input int s);
        can_frm_t f;
        f.ident   = 11'(16'h100 + c * 16 + s);
        f.len     = 4'd8;
        f.payload = {8{8'(c * 32 + s)}};
        return f;
    endfunction

    // Bit-period strobe: one cycle in four
    logic tick_en = 1'b0;
    int   tcnt = 0;
    always @(negedge clk) begin
        if (!tick_en) begin
            bit_tick <= 1'b0;
            tcnt     <= 0;
        end else begin
            bit_tick <= (tcnt == 0);
            tcnt     <= (tcnt == 3) ? 0 : tcnt + 1;
        end
    end

    // Transmitter model: 0 auto busy after start, 1 forced busy, 2 forced idle
    int bus_mode = 0;
    int busy_left = 0;
    always @(negedge clk) begin
        if (bus_mode == 1) begin
            bus_idle <= 1'b0;
        end else if (bus_mode == 2) begin
            bus_idle <= 1'b1;
        end else if (tx_start) begin
            busy_left <= 5;
            bus_idle  <= 1'b0;
        end else if (busy_left > 0) begin
            busy_left <= busy_left - 1;
            bus_idle  <= 1'b0;
        end else begin
            bus_idle <= 1'b1;
        end
    end

    // Scoreboard
    int               exp_cli [$];
    logic [FRM_W-1:0] exp_frm [$];
    int               start_at [$];
    int               n_starts = 0;
    int               idle_ticks = 0;
    logic             tick_prev = 1'b0;
    logic             idle_prev = 1'b0;

    always begin
        @(negedge clk);
        #1;
        if (rst) begin
            idle_ticks = 0;
        end else begin
            if (tx_start) begin
                n_starts++;
                start_at.push_back(idle_ticks);
                check("R3 start follows idle strobe", {tick_prev, idle_prev}, 2'b11);
                if (exp_cli.size() == 0) begin
                    check("R2 unexpected start", 1, 0);
                end else begin
                    int c;
                    logic [FRM_W-1:0] f;
                    c = exp_cli.pop_front();
                    f = exp_frm.pop_front();
                    check("R4 R5 R7 client", tx_client, c);
                    check("R4 R7 frame", tx_frame, f);
                end
            end
            if (bit_tick && bus_idle) idle_ticks++;
        end
        tick_prev = bit_tick;
        idle_prev = bus_idle;
    end

    logic [CW-1:0] wc [NC];

    task automatic do_reset();
        tick_en  = 1'b0;
        bus_mode = 0;
        @(negedge clk);
        rst = 1'b1;
        tok_we = '0;
        wr_cnt = '0;
        for (int i = 0; i < NC; i++) wc[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        start_at.delete();
    endtask

    task automatic write_only(input int c, input logic [FRM_W-1:0] f);
        @(negedge clk);
        tok_we[c]   = 1'b1;
        tok_slot[c] = wc[c][PW-1:0];
        tok_data[c] = f;
        @(negedge clk);
        tok_we[c] = 1'b0;
    endtask

    task automatic publish(input int c, input logic [FRM_W-1:0] f);
        wc[c] = wc[c] + 1'b1;
        exp_cli.push_back(c);
        exp_frm.push_back(f);
        wr_cnt[c] = wc[c];
    endtask

    task automatic push_tok(input int c, input logic [FRM_W-1:0] f);
        write_only(c, f);
        publish(c, f);
    endtask

    task automatic drain(input string req);
        int lim = 0;
        while (exp_cli.size() != 0 && lim < 2000) begin
            @(negedge clk);
            lim++;
        end
        if (lim >= 2000) check({req, " drain timeout"}, exp_cli.size(), 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int s0;
        for (int i = 0; i < NC; i++) wc[i] = '0;

        // R1: reset state
        do_reset();
        #1;
        check("R1 tx_start", tx_start, 0);
        check("R1 tx_frame", tx_frame, 0);
        check("R1 tx_client", tx_client, 0);
        check("R1 rd_cnt", rd_cnt, 0);

        // R2: token written but counter not published
        write_only(0, mk_frame(0, 0));
        tick_en = 1'b1;
        s0 = n_starts;
        repeat (40) @(negedge clk);
        check("R2 no start before publish", n_starts - s0, 0);

        // R3: published but bus busy
        bus_mode = 1;
        publish(0, mk_frame(0, 0));
        repeat (40) @(negedge clk);
        check("R3 no start while busy", n_starts - s0, 0);
        bus_mode = 0;
        drain("R3");
        check("R4 one start", n_starts - s0, 1);
        check("R4 rd_cnt advanced", rd_cnt[0], 1);

        // R5: all clients loaded, service follows the order table
        do_reset();
        for (int k = 0; k < NC; k++) push_tok(int'(ORD[k]), mk_frame(int'(ORD[k]), 0));
        tick_en = 1'b1;
        drain("R5");
        for (int k = 0; k < NC; k++) check("R5 rd_cnt each one", rd_cnt[k], 1);

        // R5: empty slots consumed, one client per idle strobe
        do_reset();
        push_tok(int'(ORD[4]), mk_frame(int'(ORD[4]), 1));
        push_tok(int'(ORD[1]), mk_frame(int'(ORD[1]), 1));
        exp_cli.delete();
        exp_frm.delete();
        exp_cli.push_back(int'(ORD[1])); exp_frm.push_back(mk_frame(int'(ORD[1]), 1));
        exp_cli.push_back(int'(ORD[4])); exp_frm.push_back(mk_frame(int'(ORD[4]), 1));
        tick_en = 1'b1;
        drain("R5");
        check("R5 start count", start_at.size(), 2);
        if (start_at.size() == 2) begin
            check("R5 first start on poll 2", start_at[0], 2);
            check("R5 second start on poll 5", start_at[1], 5);
        end

        // R7: FIFO order across counter wrap
        do_reset();
        tick_en = 1'b1;
        for (int s = 0; s < 10; s++) begin
            while (((wc[2] - rd_cnt[2]) & 3'h7) >= 3) @(negedge clk);
            push_tok(2, mk_frame(2, s));
        end
        drain("R7");
        check("R7 rd_cnt wrapped", rd_cnt[2], 3'd2);

        // R6: hold until bus shows busy then idle
        do_reset();
        bus_mode = 2;
        push_tok(int'(ORD[0]), mk_frame(int'(ORD[0]), 2));
        push_tok(int'(ORD[1]), mk_frame(int'(ORD[1]), 2));
        s0 = n_starts;
        tick_en = 1'b1;
        repeat (60) @(negedge clk);
        check("R6 held after first start", n_starts - s0, 1);
        bus_mode = 1;
        repeat (3) @(negedge clk);
        bus_mode = 2;
        drain("R6");
        check("R6 resumed with next client", n_starts - s0, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule